// File: doc/BRIEF.md
# Transaction Response Timeout Monitor

This block watches four classes of bridge transaction. Each class has one outstanding transaction at a time, and the block ends any transaction whose response is late. The four classes are:

- inbound reads that the bridge issues as an AXI master;
- inbound writes that the bridge issues as an AXI master;
- outbound reads that arrive on the AXI slave side;
- outbound non-posted writes (I/O and configuration) that arrive on the AXI slave side.

The surrounding bridge raises a start pulse when it accepts a request and a response pulse when the answer comes back. If the answer does not arrive in time, the monitor raises a one-cycle terminate strobe for that class. The strobe carries a code that tells the bridge how to end the transaction: a completer abort back toward PCIe, a silent drop, or an SLVERR toward AXI.

The two master-side limits sit in small registers. Software writes them through a one-word write port, and a value of zero switches that timer off. The slave-side limit is a fixed cycle count, 12,500,000 by default. At a 250 MHz clock this is 50 ms, and it stretches in proportion as the clock slows. An input that disables completion timeouts switches the slave-side timers off.

Top module: `resp_timeout_mon`

## Requirements
- R1: After reset, `busy_o`, `term_o` and `term_code_o` are all zero. The read limit register holds `MRD_DEF` and the write limit register holds `MWR_DEF`.
- R2: While `lim_we` is high, `lim_wdata` is loaded into the read limit when `lim_sel`=0 and into the write limit when `lim_sel`=1. The new value governs later timeouts.
- R3: A start pulse on an idle class is accepted at that clock edge, and `busy_o` for the class rises. If no response comes, the class's `term_o` bit is high for exactly one cycle. That cycle follows the L-th edge after the accepting edge, where L is the class limit. `busy_o` then returns to 0.
- R4: Class 0 (inbound read) uses the read limit. On timeout it reports code 2'b01 (completer abort) in `term_code_o[1:0]`.
- R5: Class 1 (inbound write) uses the write limit. On timeout it reports code 2'b10 (silent termination) in `term_code_o[3:2]`.
- R6: Class 2 (outbound read) and class 3 (outbound I/O or configuration write) use the fixed limit `SLV_LIMIT`. On timeout they report code 2'b11 (SLVERR) in `term_code_o[5:4]` and `term_code_o[7:6]`.
- R7: A response sampled at any edge up to and including the edge at which the timeout would fire ends the transaction as a success. No strobe follows and `busy_o` returns to 0.
- R8: A master-side limit of zero stops that class from ever timing out. It stays busy until its response arrives.
- R9: While `cto_disable` is 1, classes 2 and 3 never time out. Classes 0 and 1 are unaffected.
- R10: A start pulse on a busy class does not restart its count. A response pulse on an idle class has no effect.
- R11: Each 2-bit field of `term_code_o` is 2'b00 whenever the matching `term_o` bit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_we | input | 1 | Limit register write strobe |
| lim_sel | input | 1 | 0 selects the read limit, 1 selects the write limit |
| lim_wdata | input | MCW | Limit value to write |
| cto_disable | input | 1 | Turns off the slave-side timeouts |
| start_i | input | 4 | Per-class request accepted pulse |
| resp_i | input | 4 | Per-class response arrived pulse |
| busy_o | output | 4 | Per-class transaction outstanding |
| term_o | output | 4 | Per-class terminate strobe |
| term_code_o | output | 8 | Per-class 2-bit termination code |

## Verification
The hardest case to reach is the exact timing race in which the response lands on the very edge where the counter would expire. The bench records the edge at which each start is accepted and computes from that, counting edges, the cycle in which the response must be driven. It also drives a response one edge later, which must instead produce the strobe and then be ignored. The limit-zero and disable cases are held well past the limit while the scoreboard watches for any unexpected strobe. The bench then sends a response to prove that the class was still outstanding.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
    localparam int NCLS = 4;

    typedef enum logic [1:0] {
        TC_NONE   = 2'b00,
        TC_CABORT = 2'b01,
        TC_DROP   = 2'b10,
        TC_SLVERR = 2'b11
    } term_code_e;

    localparam int CLS_MRD = 0;
    localparam int CLS_MWR = 1;
    localparam int CLS_SRD = 2;
    localparam int CLS_SWR = 3;
endpackage

// File: rtl/rtm_limit_regs.sv
module rtm_limit_regs #(
    parameter int MCW     = 16,
    parameter int MRD_DEF = 1000,
    parameter int MWR_DEF = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lim_we,
    input  logic           lim_sel,
    input  logic [MCW-1:0] lim_wdata,
    output logic [MCW-1:0] rd_lim_o,
    output logic [MCW-1:0] wr_lim_o
);
    typedef struct packed {
        logic [MCW-1:0] rd_lim;
        logic [MCW-1:0] wr_lim;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lim_we) begin
            if (lim_sel) st_d.wr_lim = lim_wdata;
            else         st_d.rd_lim = lim_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rd_lim <= MCW'(MRD_DEF);
            st_q.wr_lim <= MCW'(MWR_DEF);
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_lim_o = st_q.rd_lim;
    assign wr_lim_o = st_q.wr_lim;

    // R2: a write to the read limit is visible on the next cycle
    assert_rd_lim_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lim_we && !lim_sel |=> rd_lim_o == $past(lim_wdata));
    // R2: a write to the write limit is visible on the next cycle
    assert_wr_lim_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lim_we && lim_sel |=> wr_lim_o == $past(lim_wdata));
endmodule

// File: rtl/rtm_tracker.sv
module rtm_tracker
    import rtm_pkg::*;
#(
    parameter int         CW   = 24,
    parameter term_code_e CODE = TC_SLVERR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [CW-1:0] lim_i,
    input  logic          start_i,
    input  logic          resp_i,
    output logic          busy_o,
    output logic          term_o,
    output logic [1:0]    code_o
);
    typedef struct packed {
        logic          busy;
        logic          term;
        logic [CW-1:0] cnt;
    } trk_t;

    trk_t st_d, st_q;
    logic expire;

    assign expire = en_i && (st_q.cnt >= (lim_i - CW'(1)));

    always_comb begin
        st_d      = st_q;
        st_d.term = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
            end
        end else if (resp_i) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (expire) begin
            st_d.busy = 1'b0;
            st_d.term = 1'b1;
            st_d.cnt  = '0;
        end else if (en_i) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign term_o = st_q.term;
    assign code_o = st_q.term ? CODE : TC_NONE;

    // R3: an accepted start opens the transaction with a cleared count
    assert_start_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o && st_q.cnt == '0);
    // R3: the terminate strobe lasts one cycle
    assert_term_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |=> !term_o);
    // R3: a strobe only ends an outstanding transaction
    assert_term_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_o) |-> $past(busy_o) && !busy_o);
    // R7: a response wins over an expiry on the same edge
    assert_resp_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && resp_i |=> !term_o && !busy_o);
    // R8 R9: a disabled timer never fires
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !term_o);
    // R10: a busy class leaves busy only through a response or a strobe
    assert_busy_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !resp_i |=> busy_o || term_o);
endmodule

// File: rtl/resp_timeout_mon.sv
module resp_timeout_mon
    import rtm_pkg::*;
#(
    parameter int MCW       = 16,
    parameter int MRD_DEF   = 1000,
    parameter int MWR_DEF   = 1000,
    parameter int SLV_LIMIT = 12_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lim_we,
    input  logic              lim_sel,
    input  logic [MCW-1:0]    lim_wdata,
    input  logic              cto_disable,
    input  logic [NCLS-1:0]   start_i,
    input  logic [NCLS-1:0]   resp_i,
    output logic [NCLS-1:0]   busy_o,
    output logic [NCLS-1:0]   term_o,
    output logic [2*NCLS-1:0] term_code_o
);
    localparam int SCW = $clog2(SLV_LIMIT + 1);
    localparam int CW  = (MCW > SCW) ? MCW : SCW;

    logic [MCW-1:0] rd_lim, wr_lim;

    rtm_limit_regs #(
        .MCW(MCW), .MRD_DEF(MRD_DEF), .MWR_DEF(MWR_DEF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_sel(lim_sel),
        .lim_wdata(lim_wdata), .rd_lim_o(rd_lim), .wr_lim_o(wr_lim)
    );

    for (genvar i = 0; i < NCLS; i++) begin : g_cls
        logic          en;
        logic [CW-1:0] lim;
        logic [1:0]    code;

        if (i == CLS_MRD) begin : g_mrd
            assign lim = CW'(rd_lim);
            assign en  = (rd_lim != '0);
        end else if (i == CLS_MWR) begin : g_mwr
            assign lim = CW'(wr_lim);
            assign en  = (wr_lim != '0);
        end else begin : g_slv
            assign lim = CW'(SLV_LIMIT);
            assign en  = !cto_disable;
        end

        localparam term_code_e CODE = (i == CLS_MRD) ? TC_CABORT :
                                      (i == CLS_MWR) ? TC_DROP : TC_SLVERR;

        rtm_tracker #(.CW(CW), .CODE(CODE)) u_trk (
            .clk(clk), .rst_n(rst_n), .en_i(en), .lim_i(lim),
            .start_i(start_i[i]), .resp_i(resp_i[i]),
            .busy_o(busy_o[i]), .term_o(term_o[i]), .code_o(code)
        );

        assign term_code_o[2*i +: 2] = code;

        // R11: the code field is clear whenever its strobe is low
        assert_code_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !term_o[i] |-> term_code_o[2*i +: 2] == 2'b00);
    end

    // R9: the disable input silences both slave-side classes
    assert_slv_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cto_disable |=> !term_o[CLS_SRD] && !term_o[CLS_SWR]);
    // R8: a zero read limit silences the inbound read class
    assert_mrd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lim == '0 |=> !term_o[CLS_MRD]);
endmodule

// File: tb/resp_timeout_mon_tb.sv
module resp_timeout_mon_tb;
    localparam int MCW = 8, MRD_DEF = 20, MWR_DEF = 30, SLV_LIMIT = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lim_we = 1'b0, lim_sel = 1'b0, cto_disable = 1'b0;
    logic [MCW-1:0] lim_wdata = '0;
    logic [3:0] start_i = '0, resp_i = '0, busy_o, term_o;
    logic [7:0] term_code_o;

    int checks = 0, errors = 0, cyc = 0, code_err = 0;
    int rd_l = MRD_DEF, wr_l = MWR_DEF;
    bit done = 0;
    int q0[$], q1[$], q2[$], q3[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    resp_timeout_mon #(.MCW(MCW), .MRD_DEF(MRD_DEF), .MWR_DEF(MWR_DEF),
                       .SLV_LIMIT(SLV_LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_sel(lim_sel),
        .lim_wdata(lim_wdata), .cto_disable(cto_disable), .start_i(start_i),
        .resp_i(resp_i), .busy_o(busy_o), .term_o(term_o), .term_code_o(term_code_o));

    function automatic logic [1:0] exp_code(int c);
        return (c == 0) ? 2'b01 : (c == 1) ? 2'b10 : 2'b11;
    endfunction

    function automatic int lim_of(int c);
        return (c == 0) ? rd_l : (c == 1) ? wr_l : SLV_LIMIT;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(int c, int t);
        case (c)
            0: q0.push_back(t);
            1: q1.push_back(t);
            2: q2.push_back(t);
            default: q3.push_back(t);
        endcase
    endtask

    // driver: start class c at the next negedge; expect a strobe if 'expect_t'
    task automatic start_cls(int c, bit expect_t);
        @(negedge clk);
        start_i[c] = 1'b1;
        if (expect_t) push(c, cyc + 1 + lim_of(c));
        @(negedge clk);
        start_i[c] = 1'b0;
    endtask

    task automatic resp_cls(int c);
        resp_i[c] = 1'b1;
        @(negedge clk);
        resp_i[c] = 1'b0;
    endtask

    task automatic wr_lim(bit sel, int v);
        @(negedge clk);
        lim_we = 1'b1; lim_sel = sel; lim_wdata = MCW'(v);
        @(negedge clk);
        lim_we = 1'b0;
        if (sel) wr_l = v; else rd_l = v;
    endtask

    // monitor: pop and compare every strobe
    always @(negedge clk) if (rst_n) begin
        for (int c = 0; c < 4; c++) begin
            if (term_o[c]) begin
                int t;
                bit have;
                have = 1'b0;
                t = -1;
                case (c)
                    0: if (q0.size() > 0) begin t = q0.pop_front(); have = 1'b1; end
                    1: if (q1.size() > 0) begin t = q1.pop_front(); have = 1'b1; end
                    2: if (q2.size() > 0) begin t = q2.pop_front(); have = 1'b1; end
                    default: if (q3.size() > 0) begin t = q3.pop_front(); have = 1'b1; end
                endcase
                check(have, "R7/R8/R9 unexpected strobe", c, -1);
                if (have) begin
                    check(t == cyc, "R3 strobe cycle", cyc, t);
                    check(term_code_o[2*c +: 2] == exp_code(c), "R4/R5/R6 code",
                          int'(term_code_o[2*c +: 2]), int'(exp_code(c)));
                end
            end else if (term_code_o[2*c +: 2] != 2'b00) begin
                code_err++;
                $display("FAIL R11 class %0d actual=%0d expected=0", c,
                         term_code_o[2*c +: 2]);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(busy_o == 0, "R1 busy", busy_o, 0);
        check(term_o == 0 && term_code_o == 0, "R1 term", term_o, 0);

        // R4 R5 R6: each class times out with its default limit
        start_cls(0, 1);
        check(busy_o[0], "R3 busy after start", busy_o[0], 1);
        start_cls(1, 1);
        start_cls(2, 1);
        start_cls(3, 1);
        repeat (50) @(negedge clk);
        check(busy_o == 0, "R3 idle after timeout", busy_o, 0);

        // R7: early response
        start_cls(0, 0);
        repeat (8) @(negedge clk);
        resp_cls(0);
        check(!busy_o[0], "R7 idle after early resp", busy_o[0], 0);

        // R7: response on the very edge of expiry (start edge N+1, expiry N+1+L)
        begin
            int n;
            @(negedge clk);
            n = cyc;
            start_i[2] = 1'b1;
            @(negedge clk);
            start_i[2] = 1'b0;
            while (cyc != n + SLV_LIMIT) @(negedge clk);
            resp_cls(2);
            check(!busy_o[2], "R7 same-edge resp idle", busy_o[2], 0);
        end
        repeat (5) @(negedge clk);

        // R10: one edge late -> strobe, then resp while idle is ignored
        begin
            int n;
            @(negedge clk);
            n = cyc;
            start_i[1] = 1'b1;
            push(1, n + 1 + wr_l);
            @(negedge clk);
            start_i[1] = 1'b0;
            while (cyc != n + wr_l + 1) @(negedge clk);
            resp_cls(1);
            check(!busy_o[1], "R10 late resp ignored", busy_o[1], 0);
        end

        // R2: reprogram read limit
        wr_lim(0, 5);
        start_cls(0, 1);
        repeat (10) @(negedge clk);
        wr_lim(1, 7);
        start_cls(1, 1);
        repeat (10) @(negedge clk);

        // R8: write limit zero never fires
        wr_lim(1, 0);
        start_cls(1, 0);
        repeat (100) @(negedge clk);
        check(busy_o[1], "R8 still busy with zero limit", busy_o[1], 1);
        resp_cls(1);
        check(!busy_o[1], "R8 resp clears", busy_o[1], 0);

        // R9: disable slave timers, master still fires
        cto_disable = 1'b1;
        start_cls(2, 0);
        start_cls(3, 0);
        start_cls(0, 1);
        repeat (80) @(negedge clk);
        check(busy_o[3:2] == 2'b11, "R9 slave held", busy_o[3:2], 3);
        resp_i[3:2] = 2'b11;
        @(negedge clk);
        resp_i[3:2] = 2'b00;
        cto_disable = 1'b0;
        check(busy_o == 0, "R9 cleared", busy_o, 0);

        // R10: restart while busy does not reset the count
        start_cls(3, 1);
        repeat (10) @(negedge clk);
        start_cls(3, 0);
        repeat (40) @(negedge clk);
        check(!busy_o[3], "R10 restart ignored", busy_o[3], 0);

        repeat (5) @(negedge clk);
        check(q0.size() + q1.size() + q2.size() + q3.size() == 0,
              "R3 all expected strobes seen",
              q0.size() + q1.size() + q2.size() + q3.size(), 0);
        checks++;
        if (code_err != 0) errors++;  // R11 tally (lines printed by monitor)
        finish_run();
    end
endmodule